// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a synchronous request port and an asynchronous static RAM that has a 16-bit data bus with per-byte enables. It accepts one word per request through a valid/ready handshake. Each request carries an address, write data, a byte mask and a read/write flag. The block then produces a correctly timed strobe sequence on the memory pins. Read data comes back through a one-cycle valid strobe.

Every timing limit of the memory is a picosecond parameter. At elaboration each limit is turned into a whole number of clock cycles, rounded up, from the clock period parameter. At the default 4 ns clock, a read holds its strobes for 12 cycles. A write holds write-enable low for 9 cycles, then keeps address, data and selects for 3 more cycles. After every read, 5 dead cycles let the memory release the bus.

The memory-side data bus is split into an output word, an output-enable and an input word, which a pad ring joins into the bidirectional bus.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1. The memory is deselected (`sram_cs1_n`=1, `sram_cs2`=0). `sram_oe_n` and `sram_we_n` are 1, and `sram_dq_oe` and `rd_valid` are 0.
- R2: A read with a non-zero mask holds `sram_oe_n` low and keeps the selects active for 12 cycles at defaults. During that time `sram_addr` holds the request address and `sram_be_n` holds the inverted mask. In the cycle after release, `rd_valid` is 1 for exactly one cycle. `rd_data` then holds the bus word, with the lanes whose mask bit is 0 set to zero.
- R3: A write with a non-zero mask holds `sram_we_n` low for 9 cycles at defaults, driving the request data on `sram_dq_o`. It then keeps `sram_we_n` high for 3 more cycles with the selects, byte enables, address and data held. Only the bytes whose mask bit is 1 are written. Mask bit 0 is the lower byte (bits 7:0) and mask bit 1 is the upper byte (bits 15:8). The byte enables are active low, so `sram_be_n` equals the inverted mask.
- R4: `sram_we_n` is low only while `sram_cs1_n` is 0, `sram_cs2` is 1 and at least one `sram_be_n` bit is 0.
- R5: `sram_be_n` does not change while the memory stays deselected. It keeps the last request's value until the next bus cycle begins.
- R6: After a read releases its strobes, `req_ready` stays 0 for 5 cycles at defaults. `sram_dq_oe` is not raised within that many cycles of `sram_oe_n` rising.
- R7: `sram_dq_oe` is 1 only during a write cycle, while the memory is selected and `sram_oe_n` is 1.
- R8: A request with an all-zero mask is accepted in one cycle and starts no bus cycle. For a read, `rd_valid` pulses in the next cycle with `rd_data` equal to zero.
- R9: While `req_ready` is 0, `req_valid` is ignored. The running cycle keeps its address and no write begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Byte mask, bit i selects byte lane i |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | DATA_W | Captured read word |
| sram_addr | output | ADDR_W | Memory address |
| sram_dq_o | output | DATA_W | Data driven toward the memory |
| sram_dq_oe | output | 1 | Enables the data drivers |
| sram_dq_i | input | DATA_W | Data arriving from the memory |
| sram_cs1_n | output | 1 | Active-low chip select |
| sram_cs2 | output | 1 | Active-high chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_be_n | output | DATA_W/8 | Active-low byte enables, bit 0 = lower byte |

## Verification
A bench memory model stores bytes on the rising edge of write-enable and drives data only while selected with output enable low. Full-word writes and reads show that data makes the round trip. Single-lane writes over known contents show that the unmasked byte survives. Single-lane reads show that lane zeroing follows the mask and not the bus. Zero-mask requests, requests held while busy, and a write issued straight after a read separate the immediate-completion path, the ignore rule and the turnaround gap from the normal cycle.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WR_LOW,
        ST_WR_END,
        ST_TURN
    } seq_state_e;

    // whole cycles covering a time span, rounded up
    function automatic int unsigned span_cycles(int unsigned span_ps, int unsigned clk_ps);
        return (span_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned max_of(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
`timescale 1ns/1ps
module sram_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_read_latch.sv
`timescale 1ns/1ps
module sram_read_latch #(
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              zero_rd,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              valid;
    } lat_t;

    lat_t lat_d, lat_q;
    logic [DATA_W-1:0] keep;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign keep[g*8 +: 8] = {8{lane_en[g]}};
    end

    always_comb begin
        lat_d       = lat_q;
        lat_d.valid = capture | zero_rd;
        if (capture)
            lat_d.data = bus_in & keep;
        else if (zero_rd)
            lat_d.data = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign rd_data  = lat_q.data;
    assign rd_valid = lat_q.valid;
endmodule

// File: rtl/sram_seq_core.sv
`timescale 1ns/1ps
module sram_seq_core
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 4,
    parameter int RD_CYC  = 12,
    parameter int WE_CYC  = 9,
    parameter int REC_CYC = 3,
    parameter int TA_CYC  = 5,
    localparam int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    input  logic              timer_zero,
    output logic              timer_load,
    output logic [CNT_W-1:0]  timer_val,
    output logic              capture,
    output logic              zero_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_drive,
    output logic              mem_sel,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [LANES-1:0]  mem_be_n
);
    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              sel;
        logic              rd;
        logic              wr;
        logic              drv;
        logic [LANES-1:0]  be_n;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        timer_load = 1'b0;
        timer_val  = '0;
        capture    = 1'b0;
        zero_rd    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: if (req_valid) begin
                if (req_mask == '0) begin
                    zero_rd = !req_write;
                end else begin
                    r_d.addr   = req_addr;
                    r_d.be_n   = ~req_mask;
                    r_d.sel    = 1'b1;
                    timer_load = 1'b1;
                    if (req_write) begin
                        r_d.st    = ST_WR_LOW;
                        r_d.wr    = 1'b1;
                        r_d.drv   = 1'b1;
                        r_d.wdata = req_wdata;
                        timer_val = CNT_W'(WE_CYC - 1);
                    end else begin
                        r_d.st    = ST_READ;
                        r_d.rd    = 1'b1;
                        timer_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_READ: if (timer_zero) begin
                capture    = 1'b1;
                r_d.sel    = 1'b0;
                r_d.rd     = 1'b0;
                r_d.st     = ST_TURN;
                timer_load = 1'b1;
                timer_val  = CNT_W'(TA_CYC - 1);
            end
            ST_WR_LOW: if (timer_zero) begin
                r_d.wr     = 1'b0;
                r_d.st     = ST_WR_END;
                timer_load = 1'b1;
                timer_val  = CNT_W'(REC_CYC - 1);
            end
            ST_WR_END: if (timer_zero) begin
                r_d.sel = 1'b0;
                r_d.drv = 1'b0;
                r_d.st  = ST_IDLE;
            end
            ST_TURN: if (timer_zero) r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.be_n <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign mem_addr  = r_q.addr;
    assign mem_dout  = r_q.wdata;
    assign mem_drive = r_q.drv;
    assign mem_sel   = r_q.sel;
    assign mem_rd_en = r_q.rd;
    assign mem_wr_en = r_q.wr;
    assign mem_be_n  = r_q.be_n;

    // cycles since output enable was last active, saturating
    logic [CNT_W-1:0] oe_gap_q;
    // cycles write enable has been held active, saturating
    logic [CNT_W-1:0] we_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_gap_q <= CNT_W'(TA_CYC);
            we_run_q <= '0;
        end else begin
            if (r_q.rd)                         oe_gap_q <= '0;
            else if (oe_gap_q < CNT_W'(TA_CYC)) oe_gap_q <= oe_gap_q + 1'b1;
            if (!r_q.wr)                        we_run_q <= '0;
            else if (we_run_q < CNT_W'(WE_CYC)) we_run_q <= we_run_q + 1'b1;
        end
    end

    // R3
    we_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.wr) |-> (we_run_q >= CNT_W'(WE_CYC)));

    // R4
    we_needs_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.wr |-> (r_q.sel && (r_q.be_n != '1)));

    // R5
    be_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.sel && $past(!r_q.sel)) |-> $stable(r_q.be_n));

    // R6
    turnaround_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.drv |-> (oe_gap_q >= CNT_W'(TA_CYC)));

    // R7
    drive_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.drv |-> (r_q.sel && !r_q.rd));
endmodule

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/1ps
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W         = 18,
    parameter int DATA_W         = 16,
    parameter int CLK_PS         = 4000,
    parameter int RD_CYCLE_PS    = 45000,
    parameter int ADDR_ACCESS_PS = 45000,
    parameter int OE_ACCESS_PS   = 22000,
    parameter int BE_ACCESS_PS   = 45000,
    parameter int RELEASE_PS     = 18000,
    parameter int WR_CYCLE_PS    = 45000,
    parameter int WE_PULSE_PS    = 35000,
    parameter int DATA_SETUP_PS  = 25000,
    parameter int ADDR_SETUP_PS  = 35000,
    localparam int LANES         = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i,
    output logic              sram_cs1_n,
    output logic              sram_cs2,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [LANES-1:0]  sram_be_n
);
    localparam int RD_CYC = max_of(1, max_of(
        max_of(span_cycles(RD_CYCLE_PS, CLK_PS), span_cycles(ADDR_ACCESS_PS, CLK_PS)),
        max_of(span_cycles(OE_ACCESS_PS, CLK_PS), span_cycles(BE_ACCESS_PS, CLK_PS))));
    localparam int WE_CYC = max_of(1, max_of(span_cycles(WE_PULSE_PS, CLK_PS),
        max_of(span_cycles(DATA_SETUP_PS, CLK_PS), span_cycles(ADDR_SETUP_PS, CLK_PS))));
    localparam int WR_TOT  = max_of(span_cycles(WR_CYCLE_PS, CLK_PS), WE_CYC + 1);
    localparam int REC_CYC = WR_TOT - WE_CYC;
    localparam int TA_CYC  = max_of(1, span_cycles(RELEASE_PS, CLK_PS));
    localparam int CNT_W   = $clog2(max_of(max_of(RD_CYC, WR_TOT), TA_CYC) + 1);

    logic             t_load, t_zero, capture, zero_rd;
    logic [CNT_W-1:0] t_val;
    logic             sel, rd_en, wr_en;

    sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    sram_seq_core #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .REC_CYC(REC_CYC), .TA_CYC(TA_CYC)
    ) u_core (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .timer_zero(t_zero), .timer_load(t_load), .timer_val(t_val),
        .capture(capture), .zero_rd(zero_rd),
        .mem_addr(sram_addr), .mem_dout(sram_dq_o), .mem_drive(sram_dq_oe),
        .mem_sel(sel), .mem_rd_en(rd_en), .mem_wr_en(wr_en), .mem_be_n(sram_be_n)
    );

    sram_read_latch #(.DATA_W(DATA_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .capture(capture), .zero_rd(zero_rd),
        .lane_en(~sram_be_n), .bus_in(sram_dq_i), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    assign sram_cs1_n = ~sel;
    assign sram_cs2   = sel;
    assign sram_oe_n  = ~rd_en;
    assign sram_we_n  = ~wr_en;
endmodule

// File: tb/sim_sram_bus_ctrl.sv
`timescale 1ns/1ps
module sim_sram_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rd_valid, sram_dq_oe, sram_cs1_n, sram_cs2, sram_oe_n, sram_we_n;
    logic [15:0] rd_data, sram_dq_o, sram_dq_i;
    logic [17:0] sram_addr;
    logic [1:0]  sram_be_n;

    int n_tests = 0, n_fail = 0;
    logic [15:0] mem [16];

    always #2 clk = ~clk;

    sram_bus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr), .sram_dq_o(sram_dq_o),
        .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i), .sram_cs1_n(sram_cs1_n),
        .sram_cs2(sram_cs2), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_be_n(sram_be_n)
    );

    // memory model: drives only when selected with output enable low
    assign sram_dq_i = (!sram_cs1_n && sram_cs2 && !sram_oe_n) ? mem[sram_addr[3:0]] : 16'hF00F;

    always @(posedge sram_we_n) begin
        if (!sram_cs1_n && sram_cs2) begin
            if (!sram_be_n[0]) mem[sram_addr[3:0]][7:0]  = sram_dq_o[7:0];
            if (!sram_be_n[1]) mem[sram_addr[3:0]][15:8] = sram_dq_o[15:8];
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
        chk(sram_cs1_n && !sram_cs2, "R1 deselect", {sram_cs1_n, sram_cs2}, 2'b10);
        chk(sram_oe_n && sram_we_n, "R1 strobes", {sram_oe_n, sram_we_n}, 2'b11);
        chk(!sram_dq_oe && !rd_valid, "R1 drive/valid", {sram_dq_oe, rd_valid}, 0);
    endtask

    task automatic t_write(input logic [3:0] a, input logic [15:0] d, input logic [1:0] m);
        logic [15:0] exp;
        int n, k;
        exp = mem[a];
        if (m[0]) exp[7:0]  = d[7:0];
        if (m[1]) exp[15:8] = d[15:8];
        issue(1'b1, 18'(a), d, m);
        n = 0;
        @(negedge clk);
        while (!sram_we_n) begin
            if (n == 0) begin
                chk(sram_dq_oe && sram_dq_o == d, "R3 data driven", 32'(sram_dq_o), 32'(d));
                chk(sram_be_n == ~m && sram_addr == 18'(a), "R3 be/addr", 32'(sram_be_n), 32'(~m));
            end
            n++;
            @(negedge clk);
        end
        chk(n == 9, "R3 we low cycles", n, 9);
        k = 0;
        while (!sram_cs1_n && sram_we_n) begin
            if (!sram_dq_oe || sram_dq_o != d) chk(0, "R3 hold data", 32'(sram_dq_o), 32'(d));
            k++;
            @(negedge clk);
        end
        chk(k == 3, "R3 recovery cycles", k, 3);
        chk(!sram_dq_oe && sram_cs1_n && !sram_cs2, "R7 released", 32'(sram_dq_oe), 0);
        chk(mem[a] == exp, "R3 memory content", 32'(mem[a]), 32'(exp));
    endtask

    task automatic t_read(input logic [3:0] a, input logic [1:0] m);
        logic [15:0] exp;
        int n, r;
        exp = mem[a] & {{8{m[1]}}, {8{m[0]}}};
        issue(1'b0, 18'(a), 16'h0, m);
        n = 0;
        @(negedge clk);
        while (!sram_oe_n) begin
            if (n == 0)
                chk(sram_addr == 18'(a) && sram_be_n == ~m && !sram_cs1_n && sram_cs2,
                    "R2 strobes", 32'(sram_be_n), 32'(~m));
            n++;
            @(negedge clk);
        end
        chk(n == 12, "R2 read window", n, 12);
        chk(rd_valid == 1'b1, "R2 valid pulse", 32'(rd_valid), 1);
        chk(rd_data == exp, "R2 read data", 32'(rd_data), 32'(exp));
        r = 0;
        while (!req_ready) begin
            if (r == 1) chk(rd_valid == 1'b0, "R2 single strobe", 32'(rd_valid), 0);
            if (sram_dq_oe) chk(0, "R6 drive in gap", 1, 0);
            r++;
            @(negedge clk);
        end
        chk(r == 5, "R6 turnaround cycles", r, 5);
        repeat (3) @(negedge clk);
        chk(sram_be_n == ~m && sram_cs1_n, "R5 be held while idle", 32'(sram_be_n), 32'(~m));
    endtask

    task automatic t_zero(input logic wr);
        issue(wr, 18'h9, 16'hFFFF, 2'b00);
        @(negedge clk);
        chk(req_ready && sram_cs1_n && sram_we_n && sram_oe_n, "R8 no bus cycle", 32'(sram_cs1_n), 1);
        chk(rd_valid == !wr, "R8 valid", 32'(rd_valid), 32'(!wr));
        if (!wr) chk(rd_data == 16'h0, "R8 zero data", 32'(rd_data), 0);
        @(negedge clk);
        chk(rd_valid == 1'b0, "R8 strobe ends", 32'(rd_valid), 0);
    endtask

    task automatic t_busy();
        logic [15:0] old;
        logic bad;
        old = mem[7];
        bad = 1'b0;
        issue(1'b0, 18'h3, 16'h0, 2'b11);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h7; req_wdata = 16'h1357; req_mask = 2'b11;
        while (!sram_oe_n) begin
            if (!sram_we_n || sram_addr != 18'h3) bad = 1'b1;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(!bad, "R9 busy request ignored", 32'(bad), 0);
        while (!req_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(mem[7] == old && sram_we_n, "R9 no write", 32'(mem[7]), 32'(old));
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'(i) * 16'h0111 ^ 16'h5A00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_write(4'h2, 16'h1234, 2'b11);
        t_read(4'h2, 2'b11);
        t_write(4'h5, 16'hAB55, 2'b01);
        t_read(4'h5, 2'b11);
        t_read(4'h5, 2'b10);
        t_write(4'h6, 16'hC3E1, 2'b10);
        t_read(4'h6, 2'b01);
        t_zero(1'b0);
        t_zero(1'b1);
        t_busy();
        t_read(4'h2, 2'b11);
        t_write(4'hA, 16'h0FF0, 2'b11);
        t_read(4'hA, 2'b11);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule